// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction fires. It takes two register operands, a 5-bit condition mask and a width mode. It evaluates five relations between the operands: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. If any relation that the mask enables is true, it raises a trap request. Taking the exception and flushing the pipeline are left to the logic that consumes the request.

In word mode only the low 32 bits of each operand take part, and bit 31 supplies the sign. In doubleword mode all 64 bits are compared. The result is registered. One cycle after an input strobe it appears together with an output strobe and a program-exception cause code that marks the event as a trap.

Top module: `trap_cmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B as signed two's-complement numbers.
- R2: Mask bit 3 (value 0x08) enables a trap when A is greater than B as signed numbers.
- R3: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R4: Mask bit 1 (value 0x02) enables a trap when A is less than B as unsigned numbers.
- R5: Mask bit 0 (value 0x01) enables a trap when A is greater than B as unsigned numbers.
- R6: With `dword_i` = 0 (word mode), only bits 31:0 of each operand are compared, and signed relations take the sign from bit 31. Bits 63:32 have no effect.
- R7: With `dword_i` = 1 (doubleword mode), all 64 bits are compared, and signed relations take the sign from bit 63.
- R8: The trap fires when at least one enabled relation holds. Disabled relations have no effect.
- R9: A mask of 0x1F traps for every operand pair. A mask of 0x00 never traps.
- R10: `done_o` equals `valid_i` delayed by one clock. `trap_o` is high only in a cycle where `done_o` is high. A cycle without `valid_i` produces `done_o` = 0 and `trap_o` = 0 one cycle later.
- R11: `cause_o` is 4'h2 (trap cause) when `trap_o` is high and 4'h0 otherwise.
- R12: While `rst_ni` is low, `done_o`, `trap_o` and `cause_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operands, mask and mode are valid this cycle |
| dword_i | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| mask_i | input | 5 | Condition mask: bit 4 signed <, bit 3 signed >, bit 2 ==, bit 1 unsigned <, bit 0 unsigned > |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| done_o | output | 1 | Result valid, one cycle after `valid_i` |
| trap_o | output | 1 | Trap request |
| cause_o | output | 4 | Program-exception cause, 4'h2 when trapping |

## Verification
The assertions assume `valid_i`, `dword_i`, `mask_i` and both operands are known (not X) on every clock edge after reset. They also assume `valid_i` is low while reset is held, so the one-cycle delay relation holds from the first cycle after reset. The bench drives every input on the falling edge, so each input is stable and defined across the rising edge. It keeps `valid_i` low during reset and idle cycles, and it randomises operands only with defined bit values.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

  // Number of relations selectable by the condition mask
  localparam int REL_N = 5;

  // Mask bit positions; the bench and the caller decode these
  typedef enum int {
    REL_UGT = 0,
    REL_ULT = 1,
    REL_EQ  = 2,
    REL_SGT = 3,
    REL_SLT = 4
  } rel_idx_e;

  typedef logic [REL_N-1:0] rel_vec_t;
  typedef logic [3:0]       cause_t;

  localparam cause_t CAUSE_NONE = 4'h0;
  localparam cause_t CAUSE_TRAP = 4'h2;

  // Result of one magnitude comparison
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } mag_t;

  // Combine the relation vector with the mask
  function automatic logic any_enabled(rel_vec_t rel, rel_vec_t mask);
    return |(rel & mask);
  endfunction

endpackage

// File: rtl/trap_cmp_operand.sv
// Widens one operand to XLEN+1 bits so that a single signed comparator
// can serve both signed and unsigned relations in either width mode.
module trap_cmp_operand #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] opnd_i,
  input  logic            dword_i,
  input  logic            signed_i,
  output logic [XLEN:0]   ext_o
);
  localparam int FILL_W = XLEN + 1 - WLEN;

  logic [WLEN-1:0] low_word;
  logic            word_fill;
  logic            dword_fill;

  assign low_word   = opnd_i[WLEN-1:0];
  assign word_fill  = signed_i & low_word[WLEN-1];
  assign dword_fill = signed_i & opnd_i[XLEN-1];

  always_comb begin
    if (dword_i) begin
      ext_o = {dword_fill, opnd_i};
    end else begin
      ext_o = {{FILL_W{word_fill}}, low_word};
    end
  end
endmodule

// File: rtl/trap_cmp_mag.sv
// Signed magnitude comparison of two equal-width vectors.
module trap_cmp_mag #(
  parameter int W = 65
) (
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output trap_cmp_pkg::mag_t res_o
);
  import trap_cmp_pkg::*;

  function automatic mag_t compare(logic [W-1:0] a, logic [W-1:0] b);
    mag_t r;
    r.lt = $signed(a) < $signed(b);
    r.gt = $signed(a) > $signed(b);
    r.eq = (a == b);
    return r;
  endfunction

  assign res_o = compare(a_i, b_i);
endmodule

// File: rtl/trap_cmp_rel.sv
// Builds the five-entry relation vector: one lane for unsigned, one for signed.
module trap_cmp_rel #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0]             opa_i,
  input  logic [XLEN-1:0]             opb_i,
  input  logic                        dword_i,
  output trap_cmp_pkg::rel_vec_t      rel_o
);
  import trap_cmp_pkg::*;

  localparam int LANES = 2;   // lane 0 unsigned, lane 1 signed
  localparam int EXT_W = XLEN + 1;

  mag_t lane_res [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [EXT_W-1:0] ext_a;
    logic [EXT_W-1:0] ext_b;

    trap_cmp_operand #(.XLEN(XLEN), .WLEN(WLEN)) u_opa (
      .opnd_i   (opa_i),
      .dword_i  (dword_i),
      .signed_i (k == 1),
      .ext_o    (ext_a)
    );

    trap_cmp_operand #(.XLEN(XLEN), .WLEN(WLEN)) u_opb (
      .opnd_i   (opb_i),
      .dword_i  (dword_i),
      .signed_i (k == 1),
      .ext_o    (ext_b)
    );

    trap_cmp_mag #(.W(EXT_W)) u_mag (
      .a_i   (ext_a),
      .b_i   (ext_b),
      .res_o (lane_res[k])
    );
  end

  always_comb begin
    rel_o          = '0;
    rel_o[REL_SLT] = lane_res[1].lt;
    rel_o[REL_SGT] = lane_res[1].gt;
    rel_o[REL_EQ]  = lane_res[0].eq;
    rel_o[REL_ULT] = lane_res[0].lt;
    rel_o[REL_UGT] = lane_res[0].gt;
  end
endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            dword_i,
  input  logic [4:0]      mask_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            done_o,
  output logic            trap_o,
  output logic [3:0]      cause_o
);
  import trap_cmp_pkg::*;

  // Named internal events, visible to the checker
  rel_vec_t rel_hits;
  logic     fire;

  trap_cmp_rel #(.XLEN(XLEN), .WLEN(WLEN)) u_rel (
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .dword_i (dword_i),
    .rel_o   (rel_hits)
  );

  assign fire = valid_i & any_enabled(rel_hits, mask_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      trap_o  <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else begin
      done_o  <= valid_i;
      trap_o  <= fire;
      cause_o <= fire ? CAUSE_TRAP : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/trap_cmp_chk.sv
module trap_cmp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        dword_i,
  input logic [4:0]  mask_i,
  input logic [63:0] opa_i,
  input logic [63:0] opb_i,
  input logic        done_o,
  input logic        trap_o,
  input logic [3:0]  cause_o,
  input logic [4:0]  rel_hits
);
  // R10
  done_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  // R10
  no_trap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !trap_o);

  // R11
  cause_on_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> cause_o == 4'h2);

  // R11
  cause_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> cause_o == 4'h0);

  // R9
  all_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == 5'h1f) |=> trap_o);

  // R9
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_i == 5'h00) |=> !trap_o);

  // R3
  dword_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dword_i && mask_i[2] && opa_i == opb_i) |=> trap_o);

  // R6
  word_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dword_i && mask_i[2] && opa_i[31:0] == opb_i[31:0]) |=> trap_o);

  // R8
  rel_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(rel_hits[4:2]) && $onehot({rel_hits[1:0], rel_hits[2]}));
endmodule

bind trap_cmp_unit trap_cmp_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .dword_i  (dword_i),
  .mask_i   (mask_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .done_o   (done_o),
  .trap_o   (trap_o),
  .cause_o  (cause_o),
  .rel_hits (rel_hits)
);

// File: tb/tb_trap_cmp_unit.sv
`timescale 1ns/1ps
module tb_trap_cmp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dword_i = 1'b0;
  logic [4:0]  mask_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        done_o;
  logic        trap_o;
  logic [3:0]  cause_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  bit    q_done[$];
  bit    q_trap[$];
  string q_tag[$];

  always #2.5 clk_i = ~clk_i;

  trap_cmp_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .dword_i(dword_i),
    .mask_i(mask_i), .opa_i(opa_i), .opb_i(opb_i),
    .done_o(done_o), .trap_o(trap_o), .cause_o(cause_o)
  );

  // Behavioural model written from the requirements
  function automatic bit model(logic [63:0] a, logic [63:0] b, bit dw, logic [4:0] m);
    bit slt, sgt, eq, ult, ugt;
    if (dw) begin
      longint sa = a;
      longint sb = b;
      slt = sa < sb;  sgt = sa > sb;
      eq  = (a == b); ult = (a < b); ugt = (a > b);
    end else begin
      int          wa = a[31:0];
      int          wb = b[31:0];
      int unsigned ua = a[31:0];
      int unsigned ub = b[31:0];
      slt = wa < wb;   sgt = wa > wb;
      eq  = (ua == ub); ult = (ua < ub); ugt = (ua > ub);
    end
    return (m[4] && slt) || (m[3] && sgt) || (m[2] && eq) || (m[1] && ult) || (m[0] && ugt);
  endfunction

  task automatic check_out(bit ev, bit et, string tag);
    logic [3:0] ec;
    ec = et ? 4'h2 : 4'h0;
    checks++;
    if (done_o !== ev || trap_o !== et || cause_o !== ec) begin
      fails++;
      $display("FAIL %s: done/trap/cause actual %b/%b/%h expected %b/%b/%h",
               tag, done_o, trap_o, cause_o, ev, et, ec);
    end
  endtask

  task automatic apply(bit v, bit dw, logic [4:0] m, logic [63:0] a, logic [63:0] b, string tag);
    @(negedge clk_i);
    valid_i = v; dword_i = dw; mask_i = m; opa_i = a; opb_i = b;
    q_done.push_back(v);
    q_trap.push_back(v && model(a, b, dw, m));
    q_tag.push_back(tag);
    @(posedge clk_i);
    #1;
    check_out(q_done.pop_front(), q_trap.pop_front(), q_tag.pop_front());
  endtask

  initial begin
    #200000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check_out(1'b0, 1'b0, "R12 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 signed less-than
    apply(1, 1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R1 -1<1");
    apply(1, 1, 5'h10, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R1 1<-1 false");
    // R2 signed greater-than
    apply(1, 1, 5'h08, 64'd1, 64'h8000_0000_0000_0000, "R2 1>min");
    apply(1, 1, 5'h08, 64'd5, 64'd5, "R2 equal false");
    // R3 equality
    apply(1, 1, 5'h04, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, "R3 eq");
    apply(1, 1, 5'h04, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF1, "R3 neq");
    // R4 unsigned less-than
    apply(1, 1, 5'h02, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R4 1<max");
    apply(1, 1, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R4 false");
    // R5 unsigned greater-than
    apply(1, 1, 5'h01, 64'h8000_0000_0000_0000, 64'd7, "R5 big>7");
    apply(1, 1, 5'h01, 64'd7, 64'd7, "R5 equal false");
    // R6 word mode ignores high half, sign from bit 31
    apply(1, 0, 5'h04, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, "R6 word eq");
    apply(1, 0, 5'h10, 64'h0000_0000_8000_0000, 64'd1, "R6 word sign31");
    apply(1, 0, 5'h02, 64'h0000_0000_8000_0000, 64'h7FFF_FFFF_0000_0001, "R6 word ult false");
    // R7 doubleword uses all bits
    apply(1, 1, 5'h04, 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, "R7 dword neq");
    apply(1, 1, 5'h10, 64'h0000_0000_8000_0000, 64'd1, "R7 dword positive");
    // R8 combined mask, only disabled relations true
    apply(1, 1, 5'h0B, 64'd3, 64'd3, "R8 eq disabled");
    apply(1, 1, 5'h12, 64'hFFFF_FFFF_FFFF_FFFE, 64'd2, "R8 slt enabled");
    // R9 all-ones and zero masks
    apply(1, 0, 5'h1F, 64'd9, 64'd9, "R9 all ones");
    apply(1, 1, 5'h00, 64'd0, 64'd0, "R9 zero mask");
    // R10 no strobe gives no result
    apply(0, 1, 5'h1F, 64'd1, 64'd1, "R10 idle");
    apply(1, 1, 5'h1F, 64'd1, 64'd2, "R10 back to back");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [4:0]  m;
      a = {$urandom, $urandom};
      b = (i % 5 == 0) ? a : {$urandom, $urandom};
      if (i % 7 == 0) b[31:0] = a[31:0];
      m = 5'($urandom);
      apply(($urandom % 4) != 0, i[0], m, a, b, "R8 random");
    end
    for (int i = 0; i < 40; i++) begin
      apply(1, i[1], (i % 2 == 0) ? 5'h1F : 5'h00, {$urandom, $urandom}, {$urandom, $urandom},
            "R9 random");
    end

    @(negedge clk_i);
    valid_i = 0;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule